// File: doc/BRIEF.md
# Sign-Magnitude Arithmetic Functional Unit

This block is one arithmetic lane of a parallel signal-processing datapath. It takes two 16-bit operands in sign-magnitude form. The sign is bit 15 and the magnitude is bits 14:0. Each accepted instruction runs one of five operations: multiply, add, multiply-accumulate, Hamming distance, or clipping. A 40-bit sign-magnitude accumulator is held inside the unit. The result is 40 bits wide in the same format: bit 39 is the sign and bits 38:0 are the magnitude.

Each instruction carries a configuration word with three parts. The opcode picks the operation. An output select chooses whether the unit returns the operation result or the accumulator. A shift flag halves the result magnitude before it is used. A separate per-instruction write enable decides whether the accumulator takes the new value.

Operands enter through a valid/ready handshake, and results leave through another one. A single output register sits between the two sides. When no instruction is offered, nothing changes.

Top module: `fu_core`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and the accumulator holds +0.
- R2: Opcode 0 (multiply) returns a magnitude equal to the product of the two operand magnitudes. The sign is the XOR of the operand signs.
- R3: Opcode 1 (add) returns the signed sum of the operands, in sign-magnitude form.
- R4: Opcode 2 (multiply-accumulate) returns the accumulator plus the signed product of the operands. The magnitude saturates at 2^39-1.
- R5: Opcode 3 returns, as a positive value, the number of bit positions in which the two 16-bit operand patterns differ.
- R6: Opcode 4 returns operand A's sign with a magnitude equal to the smaller of A's and B's magnitudes. B's sign has no effect.
- R7: When the shift flag is set, the result magnitude is shifted right by one place before it is output or written to the accumulator.
- R8: The accumulator changes only on an accepted instruction whose write enable is 1. With output select 1, the unit returns the accumulator value as it stands after that instruction. With output select 0, it returns the operation result.
- R9: A result of zero magnitude always has sign 0.
- R10: `in_ready` equals `!out_valid || out_ready`. A held output keeps `out_valid` and `out_data` stable until it is taken. Without an accepted instruction, no new output appears.
- R11: Opcodes 5 to 7 return +0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction and its operands are offered |
| in_ready | output | 1 | The unit can take an instruction this cycle |
| op_a | input | 16 | Operand A, sign-magnitude |
| op_b | input | 16 | Operand B, sign-magnitude |
| cfg_opcode | input | 3 | Operation code |
| cfg_out_sel | input | 1 | 0: output the operation result, 1: output the accumulator |
| cfg_shift | input | 1 | Halve the result magnitude |
| acc_we | input | 1 | Write the result into the accumulator |
| out_valid | output | 1 | A result is held on `out_data` |
| out_ready | input | 1 | The consumer takes the held result |
| out_data | output | 40 | Result, sign-magnitude (bit 39 sign) |

## Verification
The bench targets several corner cases, and each one shows up as a wrong value at the outputs.

Zero results are a main focus. These come from a product with a zero operand, from opposite-signed equal addends, and from operands that are themselves negative zero. A unit that skips normalisation would return sign 1 with zero magnitude.

The bench drives more than five hundred maximum-size accumulations to reach saturation, then follows them with a subtraction. Wrap-around would show up as a small magnitude. Saturation that sticks would fail to step down.

Further checks cover:
- mixing the accumulator write enable with both output selections, which catches an accumulator that updates when it should not, or a read of the stale value;
- clipping with B negative, which would expose use of B's sign;
- long output stalls under random traffic, which would expose dropped or overwritten results.

// File: rtl/fu_pkg.sv
package fu_pkg;

    typedef enum logic [2:0] {
        OP_MUL  = 3'd0,
        OP_ADD  = 3'd1,
        OP_MAC  = 3'd2,
        OP_HAM  = 3'd3,
        OP_CLIP = 3'd4
    } fu_op_e;

endpackage

// File: rtl/fu_sm_add.sv
// Sign-magnitude adder: same signs add magnitudes, opposite signs subtract
// the smaller magnitude from the larger one and keep the larger one's sign.
module fu_sm_add #(
    parameter int W = 15
) (
    input  logic         a_s,
    input  logic [W-1:0] a_m,
    input  logic         b_s,
    input  logic [W-1:0] b_m,
    output logic         sum_s,
    output logic [W:0]   sum_m
);

    always_comb begin
        if (a_s == b_s) begin
            sum_m = {1'b0, a_m} + {1'b0, b_m};
            sum_s = a_s;
        end else if (a_m >= b_m) begin
            sum_m = {1'b0, a_m} - {1'b0, b_m};
            sum_s = a_s;
        end else begin
            sum_m = {1'b0, b_m} - {1'b0, a_m};
            sum_s = b_s;
        end
        if (sum_m == '0) begin
            sum_s = 1'b0;
        end
    end

endmodule

// File: rtl/fu_popcount.sv
// Ones counter built as a chain of partial sums, one stage per input bit.
module fu_popcount #(
    parameter int W = 16
) (
    input  logic [W-1:0]           vec,
    output logic [$clog2(W+1)-1:0] cnt
);

    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] part [W+1];

    assign part[0] = '0;

    for (genvar i = 0; i < W; i++) begin : g_stage
        assign part[i+1] = part[i] + CW'(vec[i]);
    end

    assign cnt = part[W];

endmodule

// File: rtl/fu_alu.sv
// Combinational operation core. The result magnitude spans the accumulator
// magnitude width; zero normalisation of the final value is done by the caller.
module fu_alu
    import fu_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  fu_op_e          op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic            acc_s,
    input  logic [AW-2:0]   acc_m,
    output logic            res_s,
    output logic [AW-2:0]   res_m
);

    localparam int MW  = DW - 1;
    localparam int AMW = AW - 1;
    localparam int PW  = 2 * MW;
    localparam int HW  = $clog2(DW + 1);

    logic            a_s;
    logic            b_s;
    logic [MW-1:0]   a_m;
    logic [MW-1:0]   b_m;
    logic            prod_s;
    logic [PW-1:0]   prod_m;
    logic            add_s;
    logic [MW:0]     add_m;
    logic            mac_s;
    logic [AMW:0]    mac_m;
    logic [HW-1:0]   ham_cnt;
    logic [MW-1:0]   clip_m;

    assign a_s    = a[DW-1];
    assign b_s    = b[DW-1];
    assign a_m    = a[MW-1:0];
    assign b_m    = b[MW-1:0];
    assign prod_s = a_s ^ b_s;
    assign prod_m = PW'(a_m) * PW'(b_m);
    assign clip_m = (a_m > b_m) ? b_m : a_m;

    fu_sm_add #(.W(MW)) u_add (
        .a_s   (a_s),
        .a_m   (a_m),
        .b_s   (b_s),
        .b_m   (b_m),
        .sum_s (add_s),
        .sum_m (add_m)
    );

    fu_sm_add #(.W(AMW)) u_mac (
        .a_s   (acc_s),
        .a_m   (acc_m),
        .b_s   (prod_s),
        .b_m   (AMW'(prod_m)),
        .sum_s (mac_s),
        .sum_m (mac_m)
    );

    fu_popcount #(.W(DW)) u_ham (
        .vec (a ^ b),
        .cnt (ham_cnt)
    );

    always_comb begin
        res_s = 1'b0;
        res_m = '0;
        case (op)
            OP_MUL: begin
                res_s = prod_s;
                res_m = AMW'(prod_m);
            end
            OP_ADD: begin
                res_s = add_s;
                res_m = AMW'(add_m);
            end
            OP_MAC: begin
                res_s = mac_s;
                res_m = mac_m[AMW] ? {AMW{1'b1}} : mac_m[AMW-1:0];
            end
            OP_HAM: begin
                res_m = AMW'(ham_cnt);
            end
            OP_CLIP: begin
                res_s = a_s;
                res_m = AMW'(clip_m);
            end
            default: begin
                res_s = 1'b0;
                res_m = '0;
            end
        endcase
    end

endmodule

// File: rtl/fu_core.sv
module fu_core
    import fu_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [2:0]    cfg_opcode,
    input  logic          cfg_out_sel,
    input  logic          cfg_shift,
    input  logic          acc_we,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [AW-1:0] out_data
);

    localparam int AMW = AW - 1;

    typedef struct packed {
        logic            vld;
        logic [AW-1:0]   dout;
        logic            acc_s;
        logic [AMW-1:0]  acc_m;
    } fu_state_t;

    fu_state_t       st_d;
    fu_state_t       st_q;
    logic            take;
    logic            alu_s;
    logic [AMW-1:0]  alu_m;
    logic            sh_s;
    logic [AMW-1:0]  sh_m;

    fu_alu #(.DW(DW), .AW(AW)) u_alu (
        .op    (fu_op_e'(cfg_opcode)),
        .a     (op_a),
        .b     (op_b),
        .acc_s (st_q.acc_s),
        .acc_m (st_q.acc_m),
        .res_s (alu_s),
        .res_m (alu_m)
    );

    assign in_ready  = !st_q.vld || out_ready;
    assign take      = in_valid && in_ready;
    assign out_valid = st_q.vld;
    assign out_data  = st_q.dout;

    always_comb begin
        st_d = st_q;
        sh_m = cfg_shift ? (alu_m >> 1) : alu_m;
        sh_s = alu_s && (sh_m != '0);
        if (st_q.vld && out_ready) begin
            st_d.vld = 1'b0;
        end
        if (take) begin
            st_d.vld = 1'b1;
            if (acc_we) begin
                st_d.acc_s = sh_s;
                st_d.acc_m = sh_m;
            end
            st_d.dout = cfg_out_sel ? {st_d.acc_s, st_d.acc_m} : {sh_s, sh_m};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data != {1'b1, {AMW{1'b0}}}));                       // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));        // R10
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && (!out_valid || out_ready)) |=> !out_valid);               // R10
    AST_ACC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && acc_we) |=> ($stable(st_q.acc_m) && $stable(st_q.acc_s)));   // R8
    AST_HAM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_opcode == OP_HAM) |-> (!alu_s && alu_m <= AMW'(DW)));  // R5
    AST_CLIP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_opcode == OP_CLIP) |-> (alu_m <= AMW'(op_b[DW-2:0]))); // R6
    AST_SHIFT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cfg_shift && !cfg_out_sel) |=> (out_data[AW-2] == 1'b0));     // R7

endmodule

// File: tb/fu_core_tb.sv
`timescale 1ns/1ps
module fu_core_tb;

    localparam int DW = 16;
    localparam int AW = 40;
    localparam longint MAXM = (longint'(1) << 39) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] op_a = '0;
    logic [DW-1:0] op_b = '0;
    logic [2:0]    cfg_opcode = '0;
    logic          cfg_out_sel = 1'b0;
    logic          cfg_shift = 1'b0;
    logic          acc_we = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [AW-1:0] out_data;

    int     tests = 0;
    int     fails = 0;
    string  req = "R1";
    bit     exp_vld = 1'b0;
    logic [AW-1:0] exp_dout = '0;
    longint acc_v = 0;

    always #2.5 clk = ~clk;

    fu_core #(.DW(DW), .AW(AW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .op_a        (op_a),
        .op_b        (op_b),
        .cfg_opcode  (cfg_opcode),
        .cfg_out_sel (cfg_out_sel),
        .cfg_shift   (cfg_shift),
        .acc_we      (acc_we),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data)
    );

    function automatic logic [15:0] sm(input int v);
        if (v < 0) return {1'b1, 15'(-v)};
        return {1'b0, 15'(v)};
    endfunction

    function automatic longint val(input logic [15:0] x);
        if (x[15]) return -longint'(x[14:0]);
        return longint'(x[14:0]);
    endfunction

    function automatic logic [AW-1:0] enc(input longint v);
        if (v < 0) return {1'b1, 39'(-v)};
        return {1'b0, 39'(v)};
    endfunction

    task automatic chk(input bit ok, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, update the model for the rising
    // edge, compare at the next falling edge.
    task automatic cyc(input bit iv, input int op, input logic [15:0] a, input logic [15:0] b,
                       input bit sel, input bit sh, input bit we, input bit ordy);
        bit     acc_take;
        longint r;
        longint m;
        int     cnt;
        in_valid = iv; cfg_opcode = 3'(op); op_a = a; op_b = b;
        cfg_out_sel = sel; cfg_shift = sh; acc_we = we; out_ready = ordy;
        #1;
        chk(in_ready == (!exp_vld || ordy), "in_ready", AW'(in_ready), AW'(!exp_vld || ordy));
        acc_take = iv && (!exp_vld || ordy);
        if (exp_vld && ordy) exp_vld = 1'b0;
        if (acc_take) begin
            case (op)
                0: r = val(a) * val(b);
                1: r = val(a) + val(b);
                2: begin
                    r = acc_v + val(a) * val(b);
                    if (r > MAXM) r = MAXM;
                    if (r < -MAXM) r = -MAXM;
                end
                3: begin
                    cnt = 0;
                    for (int i = 0; i < 16; i++) cnt += int'(a[i] ^ b[i]);
                    r = cnt;
                end
                4: begin
                    m = (a[14:0] < b[14:0]) ? longint'(a[14:0]) : longint'(b[14:0]);
                    r = a[15] ? -m : m;
                end
                default: r = 0;
            endcase
            if (sh) r = (r < 0) ? -((-r) >>> 1) : (r >>> 1);
            if (we) acc_v = r;
            exp_dout = enc(sel ? acc_v : r);
            exp_vld = 1'b1;
        end
        @(negedge clk);
        chk(out_valid == exp_vld, "out_valid", AW'(out_valid), AW'(exp_vld));
        if (exp_vld) chk(out_data == exp_dout, "out_data", out_data, exp_dout);
    endtask

    task automatic run(input int op, input int a, input int b, input bit sel, input bit sh, input bit we);
        cyc(1'b1, op, sm(a), sm(b), sel, sh, we, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        req = "R1";
        chk(out_valid == 1'b0, "reset out_valid", AW'(out_valid), '0);
        chk(in_ready == 1'b1, "reset in_ready", AW'(in_ready), AW'(1));
        rst_n = 1'b1;
        run(0, 9, 9, 1, 0, 0);                     // R1: accumulator reads +0
        req = "R2";
        run(0, 3, 4, 0, 0, 0);
        run(0, -3, 4, 0, 0, 0);
        run(0, -3, -4, 0, 0, 0);
        run(0, 32767, 32767, 0, 0, 0);
        run(0, -7, 32767, 0, 0, 0);
        req = "R3";
        run(1, 5, 9, 0, 0, 0);
        run(1, -5, 9, 0, 0, 0);
        run(1, 5, -9, 0, 0, 0);
        run(1, -20, -30, 0, 0, 0);
        run(1, 32767, 32767, 0, 0, 0);
        req = "R9";
        run(0, -5, 0, 0, 0, 0);
        run(1, -3, 3, 0, 0, 0);
        cyc(1'b1, 1, 16'h8000, 16'h8000, 0, 0, 0, 1'b1);
        cyc(1'b1, 4, 16'h8000, sm(7), 0, 0, 0, 1'b1);
        req = "R5";
        cyc(1'b1, 3, 16'hFFFF, 16'h0000, 0, 0, 0, 1'b1);
        cyc(1'b1, 3, 16'hA5A5, 16'hA5A5, 0, 0, 0, 1'b1);
        cyc(1'b1, 3, 16'h8001, 16'h0003, 0, 0, 0, 1'b1);
        req = "R6";
        run(4, -1000, 200, 0, 0, 0);
        run(4, 50, -200, 0, 0, 0);
        run(4, 300, -200, 0, 0, 0);
        req = "R11";
        run(5, 11, 12, 0, 0, 0);
        run(6, -11, 12, 0, 0, 0);
        run(7, 11, -12, 0, 0, 0);
        req = "R7";
        run(0, 3, 5, 0, 1, 0);
        run(0, -3, 5, 0, 1, 0);
        run(0, -1, 1, 0, 1, 0);
        req = "R8";
        run(0, 6, -7, 1, 0, 1);
        run(1, 100, 100, 1, 0, 0);
        run(3, 100, 1, 0, 0, 0);
        run(1, 100, 100, 0, 0, 1);
        run(0, 1, 1, 1, 0, 0);
        req = "R4";
        run(0, 0, 0, 0, 0, 1);
        run(2, 3, 4, 1, 0, 1);
        run(2, -2, 10, 1, 0, 1);
        for (int k = 0; k < 600; k++) run(2, 32767, 32767, 1, 0, 1);
        run(2, -1, 1, 1, 0, 1);
        run(2, 1, 1, 1, 1, 1);
        req = "R10";
        cyc(1'b1, 0, sm(2), sm(3), 0, 0, 0, 1'b0);
        cyc(1'b1, 0, sm(4), sm(5), 0, 0, 0, 1'b0);
        cyc(1'b1, 0, sm(4), sm(5), 0, 0, 0, 1'b0);
        cyc(1'b0, 0, sm(0), sm(0), 0, 0, 0, 1'b1);
        cyc(1'b0, 0, sm(0), sm(0), 0, 0, 0, 1'b1);
        for (int k = 0; k < 3000; k++) begin
            cyc(1'($urandom % 3 != 0), int'($urandom % 8), 16'($urandom), 16'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom % 4 != 0));
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog %s actual=running expected=done", req);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule